// File: doc/BRIEF.md
# Pipelined Bus Cycle Controller

This block is the master-side sequencer for a 32-bit processor bus. Internal logic hands it one transfer at a time through a valid/ready request port. Each transfer carries a word address, four byte enables and a cycle type: write or read, data or control, memory or I/O. The controller places these on the external bus, marks them with a one-clock address strobe, and then holds the cycle in its data phase until the external ready input acknowledges it. Every clock in which ready is low adds one wait state, and there is no limit on how many.

Address timing is chosen for each cycle on its own. Suppose a data-phase clock has ready still low, the next-address input high and another request waiting. The controller then drives the waiting request's address and type early, with a fresh strobe, while the current cycle is still waiting. The early cycle then needs only one data-phase clock after the previous one ends. When nothing is pending, the controller goes idle, and the next request again starts with a plain address phase. Each completion is reported by a one-clock done pulse, which carries the sampled read data and the write flag of the finished cycle. Every output comes from a register, and an active-high synchronous reset returns the block to idle.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After a synchronous reset, bus_ads is 0, done is 0 and req_ready is 1, and the controller is idle.
- R2: A request accepted while idle produces bus_ads high for exactly one clock, with the request's address, byte enables, write, data/control and memory/IO fields on the bus. The ready input is not sampled in that clock. If ready is high in the following clock, done is high two clocks after the strobe clock.
- R3: Each data-phase clock with bus_ready low adds one clock before done, and done stays low during it. The bus address, byte enable and type lines change only in a clock where bus_ads is high.
- R4: If ready is sampled high while a further request is pending, the next strobe comes in the very next clock, with no idle clock between. Back-to-back cycles with no wait states therefore place strobes exactly two clocks apart.
- R5: Suppose a data-phase clock has bus_ready low, bus_next high and a request pending. In the next clock, bus_ads is high with the pending request's fields, and the current cycle has not yet completed.
- R6: bus_next has no effect when no request is pending: no extra strobe appears, and the cycle ends only on ready.
- R7: bus_next has no effect in a clock where bus_ready is high. A pending request then gets a normal address phase followed by a data phase.
- R8: bus_ads is asserted exactly once per cycle and never in two consecutive clocks. A cycle issued early completes one clock after the previous cycle if ready is high in its first data-phase clock, which gives done pulses in consecutive clocks.
- R9: At most one cycle is issued ahead. While an early-issued cycle waits behind the current one, bus_next is ignored, and no further strobe occurs until the current cycle is acknowledged.
- R10: Cycles complete in the order they were issued, one done pulse each. For a read, done_rdata equals bus_rdata as sampled in the acknowledging clock. done_wr equals the write flag of the completed cycle (1 for write).
- R11: With no request pending after an acknowledge, the controller idles with bus_ads low. A request arriving from idle always starts with a non-overlapped address phase (strobe-to-done of two clocks plus wait states).
- R12: A synchronous reset in the middle of a cycle abandons it. Outputs return to the R1 state, and no done pulse ever appears for the abandoned cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request holding slot is empty |
| req_addr | input | 30 | Word address of the request |
| req_be | input | 4 | Byte enables, active high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dc | input | 1 | 1 = data, 0 = control |
| req_mio | input | 1 | 1 = memory, 0 = I/O |
| bus_addr | output | 30 | Bus word address |
| bus_be | output | 4 | Bus byte enables, active high |
| bus_wr | output | 1 | Bus write/read definition |
| bus_dc | output | 1 | Bus data/control definition |
| bus_mio | output | 1 | Bus memory/IO definition |
| bus_ads | output | 1 | Address strobe, active high, one clock per cycle |
| bus_ready | input | 1 | Cycle acknowledge, active high |
| bus_next | input | 1 | Next-address request, active high |
| bus_rdata | input | 32 | Read data from the bus |
| done | output | 1 | One-clock completion pulse |
| done_wr | output | 1 | Write flag of the completed cycle |
| done_rdata | output | 32 | Read data of the completed cycle |

## Verification
The controller runs against a bus responder that acknowledges each strobed cycle after a programmed number of wait states. The tests cover single cycles with zero and several waits, back-to-back streams with next-address held low and held high, an early issue followed by a zero-wait cycle, a long wait with two requests queued behind it, and a reset in the middle of a cycle. Strobe-to-done and done-to-done spacings show overlapped timing apart from plain timing. Next-address held high with immediate ready, or with nothing pending, must look exactly like plain timing. The queued-pair pattern shows whether the controller ever issues two cycles ahead. A mixed stream of reads and writes with varying byte enables and types checks the field order and data in the scoreboard.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic wr;
        logic dc;
        logic mio;
    } cyc_def_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        cyc_def_t          def;
    } bus_req_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2,
        ST_T2P  = 2'd3
    } bus_st_t;

    function automatic logic in_data_phase(bus_st_t s);
        return (s == ST_T2) || (s == ST_T2P);
    endfunction

endpackage

// File: rtl/bcc_req_slot.sv
module bcc_req_slot
    import bcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  bus_req_t in_req,
    input  logic     take,
    output logic     empty_o,
    output bus_req_t held_o
);

    logic     empty_q;
    bus_req_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            held_q  <= '0;
        end else if (in_valid && empty_q) begin
            empty_q <= 1'b0;
            held_q  <= in_req;
        end else if (take) begin
            empty_q <= 1'b1;
        end
    end

    assign empty_o = empty_q;
    assign held_o  = held_q;

    // R4: the sequencer only issues a request the slot actually holds
    assert_take_full_R4: assert property (@(posedge clk) disable iff (rst)
        take |-> !empty_q);

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pend,
    input  logic    rdy,
    input  logic    na,
    output bus_st_t st_o,
    output logic    issue_o,
    output logic    ack_o
);

    bus_st_t st_q, st_n;
    logic    issue, ack;

    always_comb begin
        st_n  = st_q;
        issue = 1'b0;
        ack   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                issue = pend;
                st_n  = pend ? ST_T1 : ST_IDLE;
            end
            ST_T1: begin
                st_n = ST_T2;
            end
            ST_T2: begin
                if (rdy) begin
                    ack   = 1'b1;
                    issue = pend;
                    st_n  = pend ? ST_T1 : ST_IDLE;
                end else if (na && pend) begin
                    issue = 1'b1;
                    st_n  = ST_T2P;
                end
            end
            ST_T2P: begin
                if (rdy) begin
                    ack  = 1'b1;
                    st_n = ST_T2;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_n;
    end

    assign st_o    = st_q;
    assign issue_o = issue;
    assign ack_o   = ack;

    // R2: an address phase lasts one clock and is followed by a data phase
    assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_T1) |=> (st_q == ST_T2));

    // R9: nothing is issued while one cycle is already queued on the bus
    assert_ahead_once_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_T2P) |-> !issue);

endmodule

// File: rtl/bcc_bus_drv.sv
module bcc_bus_drv
    import bcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     issue,
    input  bus_req_t req_i,
    output bus_req_t bus_o,
    output logic     ads_o,
    output logic     prev_wr_o
);

    bus_req_t bus_q;
    logic     ads_q;
    logic     prev_wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q     <= '0;
            ads_q     <= 1'b0;
            prev_wr_q <= 1'b0;
        end else begin
            ads_q <= issue;
            if (issue) begin
                prev_wr_q <= bus_q.def.wr;
                bus_q     <= req_i;
            end
        end
    end

    assign bus_o     = bus_q;
    assign ads_o     = ads_q;
    assign prev_wr_o = prev_wr_q;

    // R8: a strobe never lasts more than one clock
    assert_ads_once_R8: assert property (@(posedge clk) disable iff (rst)
        ads_q |=> !ads_q);

endmodule

// File: rtl/bcc_done.sv
module bcc_done
    import bcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              done_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              done_q;
    logic              wr_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= ack;
            if (ack) begin
                wr_q    <= wr_i;
                rdata_q <= rdata_i;
            end
        end
    end

    assign done_o  = done_q;
    assign wr_o    = wr_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_wr,
    input  logic              req_dc,
    input  logic              req_mio,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic              bus_wr,
    output logic              bus_dc,
    output logic              bus_mio,
    output logic              bus_ads,
    input  logic              bus_ready,
    input  logic              bus_next,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              done_wr,
    output logic [DATA_W-1:0] done_rdata
);

    bus_req_t in_req, held, bus_q;
    logic     slot_empty, pend, issue, ack, prev_wr, done_wr_sel;
    bus_st_t  st;

    assign in_req.addr    = req_addr;
    assign in_req.be      = req_be;
    assign in_req.def.wr  = req_wr;
    assign in_req.def.dc  = req_dc;
    assign in_req.def.mio = req_mio;

    bcc_req_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .in_valid(req_valid),
        .in_req  (in_req),
        .take    (issue),
        .empty_o (slot_empty),
        .held_o  (held)
    );

    assign pend      = !slot_empty;
    assign req_ready = slot_empty;

    bcc_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .rdy    (bus_ready),
        .na     (bus_next),
        .st_o   (st),
        .issue_o(issue),
        .ack_o  (ack)
    );

    bcc_bus_drv u_drv (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue),
        .req_i    (held),
        .bus_o    (bus_q),
        .ads_o    (bus_ads),
        .prev_wr_o(prev_wr)
    );

    assign bus_addr = bus_q.addr;
    assign bus_be   = bus_q.be;
    assign bus_wr   = bus_q.def.wr;
    assign bus_dc   = bus_q.def.dc;
    assign bus_mio  = bus_q.def.mio;

    // while a queued cycle sits on the bus, the finishing cycle is the older one
    assign done_wr_sel = (st == ST_T2P) ? prev_wr : bus_q.def.wr;

    bcc_done u_done (
        .clk    (clk),
        .rst    (rst),
        .ack    (ack),
        .wr_i   (done_wr_sel),
        .rdata_i(bus_rdata),
        .done_o (done),
        .wr_o   (done_wr),
        .rdata_o(done_rdata)
    );

    // R2: ready sampled in a data phase completes the cycle next clock
    assert_done_on_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (in_data_phase(st) && bus_ready) |=> done);

    // R3: a wait state keeps the bus lines and produces no completion
    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T2 && !bus_ready && !(bus_next && pend))
        |=> ($stable(bus_addr) && $stable(bus_be) && !bus_ads && !done));

    // R5: early issue strobes the next cycle before the current one ends
    assert_early_issue_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T2 && !bus_ready && bus_next && pend)
        |=> (bus_ads && !done && st == ST_T2P));

    // R11: with nothing pending the controller stays idle and quiet
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !pend) |=> (!bus_ads && st == ST_IDLE));

endmodule

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [29:0] a;
        logic [3:0]  be;
        logic        wr;
        logic        dc;
        logic        mio;
        int          w;
    } item_t;

    typedef struct {
        logic [29:0] a;
        int          w;
        int          t;
    } resp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [29:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        req_wr = 1'b0, req_dc = 1'b0, req_mio = 1'b0;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_wr, bus_dc, bus_mio, bus_ads;
    logic        bus_ready = 1'b0;
    logic        bus_next = 1'b0;
    logic [31:0] bus_rdata = 32'hDEAD_BEEF;
    logic        done, done_wr;
    logic [31:0] done_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic na_en = 1'b0;

    item_t drv_q[$], exp_ads[$], exp_done[$];
    resp_t resp_q[$];
    int    ads_t[$], done_t[$];

    logic [29:0] p_addr;
    logic [3:0]  p_be;
    logic [2:0]  p_def;
    logic        p_ads;

    bus_cycle_ctrl dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be),
        .req_wr(req_wr), .req_dc(req_dc), .req_mio(req_mio),
        .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wr(bus_wr), .bus_dc(bus_dc), .bus_mio(bus_mio),
        .bus_ads(bus_ads), .bus_ready(bus_ready), .bus_next(bus_next),
        .bus_rdata(bus_rdata),
        .done(done), .done_wr(done_wr), .done_rdata(done_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_word(logic [29:0] a);
        return {a, 2'b01} ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor, scoreboard, bus responder and request driver in a fixed order
    always @(negedge clk) begin
        item_t it;
        resp_t r;
        if (rst) begin
            req_valid = 1'b0;
            bus_ready = 1'b0;
            p_addr = bus_addr; p_be = bus_be;
            p_def = {bus_wr, bus_dc, bus_mio}; p_ads = bus_ads;
        end else begin
            // R3: bus lines move only with a strobe
            if (!bus_ads)
                check({bus_addr, bus_be, bus_wr, bus_dc, bus_mio} == {p_addr, p_be, p_def},
                      "R3 bus lines changed without strobe",
                      {bus_be, bus_addr[27:0]}, {p_be, p_addr[27:0]});
            // R8: no strobe in two consecutive clocks
            if (bus_ads)
                check(!p_ads, "R8 strobe held two clocks", 32'(bus_ads & p_ads), 0);
            if (bus_ads) begin
                ads_t.push_back(cyc);
                if (exp_ads.size() == 0) begin
                    check(0, "R2 unexpected strobe", 32'(bus_addr), 0);
                    r = '{a: bus_addr, w: 0, t: cyc};
                end else begin
                    it = exp_ads.pop_front();
                    check(bus_addr == it.a, "R2 strobe address", 32'(bus_addr), 32'(it.a));
                    check({bus_be, bus_wr, bus_dc, bus_mio} == {it.be, it.wr, it.dc, it.mio},
                          "R2 strobe byte enables and type",
                          32'({bus_be, bus_wr, bus_dc, bus_mio}),
                          32'({it.be, it.wr, it.dc, it.mio}));
                    r = '{a: bus_addr, w: it.w, t: cyc};
                end
                resp_q.push_back(r);
            end
            if (done) begin
                done_t.push_back(cyc);
                if (exp_done.size() == 0) begin
                    check(0, "R10 unexpected done", 32'(done), 0);
                end else begin
                    it = exp_done.pop_front();
                    check(done_wr == it.wr, "R10 done write flag", 32'(done_wr), 32'(it.wr));
                    if (!it.wr)
                        check(done_rdata == mem_word(it.a), "R10 read data",
                              done_rdata, mem_word(it.a));
                end
            end
            p_addr = bus_addr; p_be = bus_be;
            p_def = {bus_wr, bus_dc, bus_mio}; p_ads = bus_ads;

            // responder: front cycle is in a data phase once its strobe clock is past
            bus_ready = 1'b0;
            bus_rdata = 32'hDEAD_BEEF;
            if (resp_q.size() > 0 && resp_q[0].t < cyc) begin
                r = resp_q.pop_front();
                if (r.w == 0) begin
                    bus_ready = 1'b1;
                    bus_rdata = mem_word(r.a);
                end else begin
                    r.w = r.w - 1;
                    resp_q.push_front(r);
                end
            end
            bus_next = na_en;

            // driver: offer only when the slot is seen empty, so the handshake is certain
            if (drv_q.size() > 0 && req_ready) begin
                it = drv_q.pop_front();
                req_valid = 1'b1;
                req_addr = it.a; req_be = it.be;
                req_wr = it.wr; req_dc = it.dc; req_mio = it.mio;
                exp_ads.push_back(it);
                exp_done.push_back(it);
            end else begin
                req_valid = 1'b0;
            end
        end
    end

    task automatic sync();
        @(posedge clk);
        #1;
    endtask

    task automatic add(input logic [29:0] a, input logic [3:0] be, input logic wr,
                       input logic dc, input logic mio, input int w);
        item_t it;
        it = '{a: a, be: be, wr: wr, dc: dc, mio: mio, w: w};
        drv_q.push_back(it);
    endtask

    task automatic start(input logic na);
        sync();
        na_en = na;
        ads_t.delete();
        done_t.delete();
    endtask

    task automatic finish_run(input int n);
        while (done_t.size() < n) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            check(!bus_ads, "R11 strobe while idle", 32'(bus_ads), 0);
        end
    endtask

    task automatic do_reset();
        sync();
        rst = 1'b1;
        na_en = 1'b0;
        drv_q.delete(); exp_ads.delete(); exp_done.delete(); resp_q.delete();
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=completion");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        do_reset();
        @(negedge clk);
        check(!bus_ads && !done && req_ready, "R1 reset state",
              32'({bus_ads, done, req_ready}), 32'b001);

        // single read, no waits
        start(0);
        add(30'h100, 4'hF, 0, 1, 1, 0);
        finish_run(1);
        check(done_t[0] - ads_t[0] == 2, "R2 zero-wait latency",
              done_t[0] - ads_t[0], 2);

        // single write with three wait states
        start(0);
        add(30'h2A5, 4'h3, 1, 1, 0, 3);
        finish_run(1);
        check(done_t[0] - ads_t[0] == 5, "R3 wait-state latency",
              done_t[0] - ads_t[0], 5);

        // back-to-back plain cycles
        start(0);
        for (int i = 0; i < 4; i++) add(30'h300 + 30'(i), 4'hF, 0, 1, 1, 0);
        finish_run(4);
        for (int i = 0; i < 3; i++) begin
            check(ads_t[i+1] - ads_t[i] == 2, "R4 strobe spacing",
                  ads_t[i+1] - ads_t[i], 2);
            check(done_t[i+1] - done_t[i] == 2, "R4 done spacing",
                  done_t[i+1] - done_t[i], 2);
        end

        // next-address high but ready immediate: plain timing
        start(1);
        for (int i = 0; i < 3; i++) add(30'h400 + 30'(i), 4'hC, 0, 0, 1, 0);
        finish_run(3);
        for (int i = 0; i < 2; i++)
            check(ads_t[i+1] - ads_t[i] == 2, "R7 strobe spacing with next high",
                  ads_t[i+1] - ads_t[i], 2);
        check(done_t[2] - done_t[1] == 2, "R7 done spacing with next high",
              done_t[2] - done_t[1], 2);

        // early issue then a zero-wait cycle
        start(1);
        add(30'h500, 4'hF, 0, 1, 1, 1);
        add(30'h501, 4'h1, 1, 1, 1, 0);
        finish_run(2);
        check(ads_t[1] < done_t[0], "R5 second strobe before first done",
              ads_t[1], done_t[0]);
        check(ads_t[1] - ads_t[0] == 2, "R5 early strobe clock",
              ads_t[1] - ads_t[0], 2);
        check(done_t[1] - done_t[0] == 1, "R8 early cycle completes next clock",
              done_t[1] - done_t[0], 1);
        check(ads_t.size() == 2, "R8 one strobe per cycle", ads_t.size(), 2);

        // next-address high with nothing pending
        start(1);
        add(30'h600, 4'hF, 0, 1, 1, 3);
        finish_run(1);
        check(ads_t.size() == 1, "R6 no extra strobe", ads_t.size(), 1);
        check(done_t[0] - ads_t[0] == 5, "R6 latency unchanged",
              done_t[0] - ads_t[0], 5);

        // long wait with two requests queued: only one goes ahead
        start(1);
        add(30'h700, 4'hF, 0, 1, 1, 4);
        add(30'h701, 4'hF, 0, 1, 1, 0);
        add(30'h702, 4'hF, 1, 0, 0, 0);
        finish_run(3);
        cnt = 0;
        foreach (ads_t[i]) if (ads_t[i] < done_t[0]) cnt++;
        check(cnt == 2, "R9 strobes before first done", cnt, 2);
        check(done_t[2] - ads_t[2] == 2, "R9 third cycle plain timing",
              done_t[2] - ads_t[2], 2);

        // reset in the middle of a long cycle
        start(0);
        add(30'h800, 4'hF, 0, 1, 1, 50);
        while (ads_t.size() < 1) @(negedge clk);
        repeat (4) @(negedge clk);
        do_reset();
        done_t.delete();
        @(negedge clk);
        check(!bus_ads && !done && req_ready, "R12 state after mid-cycle reset",
              32'({bus_ads, done, req_ready}), 32'b001);
        repeat (60) @(negedge clk);
        check(done_t.size() == 0, "R12 abandoned cycle never completes",
              done_t.size(), 0);

        // fresh request from idle after reset
        start(0);
        add(30'h900, 4'h6, 1, 0, 1, 1);
        finish_run(1);
        check(done_t[0] - ads_t[0] == 3, "R11 request from idle starts plain",
              done_t[0] - ads_t[0], 3);

        // mixed stream with overlap enabled
        start(1);
        for (int i = 0; i < 6; i++)
            add(30'h2000 + 30'(i * 3), 4'(1 << (i % 4)) | 4'h8, i[0], i[1], ~i[0], (i * 2) % 3);
        finish_run(6);
        check(done_t.size() == 6 && ads_t.size() == 6, "R10 one done per strobe",
              done_t.size(), ads_t.size());
        check(exp_done.size() == 0, "R10 all cycles completed", exp_done.size(), 0);

        summary();
        $finish;
    end
endmodule